// File: doc/BRIEF.md
# Runtime-Configurable Asynchronous Serial Receiver

This block takes a raw asynchronous serial line and turns each character on it into a parallel byte. Every register runs on one fast system clock. Bit timing comes from a single-cycle enable pulse that fires once per baud divisor's worth of clock cycles. Sixteen of these pulses make one bit time, so the system clock must run at least sixteen times the bit rate. The divisor can take any value, so the baud rate is not limited to a fixed set. The line passes through a two-stage synchroniser before any edge is looked for.

The character length can be set to 5, 6, 7 or 8 data bits, and the stop bit count to one or two. Both settings are inputs and can change at runtime between characters. A falling edge only counts as a start bit if the line is still low half a bit later. Each bit is sampled at its centre. When a stop bit reads low, the character is still delivered, together with a framing error flag. Once a character ends, the receiver waits until the line is high again before it will look for another start edge.

Top module: `serial_frame_rx`

## Requirements
- R1: While reset is held and just after it is released, `rx_valid`, `busy` and `frame_err` are 0 and `rx_data` is 0.
- R2: An 8-bit character (`len_sel`=3) with one stop bit is received least significant bit first. Its value appears on `rx_data` together with a one-cycle `rx_valid` pulse, and `frame_err` is 0.
- R3: `len_sel` selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The data is right-justified in `rx_data` and the unused upper bits are 0.
- R4: With `two_stop`=1 the receiver samples two stop bits. A low level in the second stop bit alone sets `frame_err`.
- R5: A low stop bit sets `frame_err` for that character. `rx_valid` still pulses and `rx_data` still holds the received data bits.
- R6: A low pulse that ends before the centre of the start bit (8 oversample ticks) produces no character, and the receiver returns to idle (`busy`=0).
- R7: One oversample tick occurs every `baud_div` clock cycles, and a bit time is 16 ticks. A value of 0 is treated as 1. Characters are received correctly with any divisor, including 1.
- R8: After a character, no new start edge is accepted until the line has been high. A line held low (break) produces exactly one character, with `frame_err`=1 and data 0. `busy` stays high until the line returns high.
- R9: `rx_valid` is high for exactly one cycle per character. `busy` is high from the detected start edge until the receiver is idle again.
- R10: `rx_data` and `frame_err` change only in the cycle `rx_valid` is high. A good character after a framing error clears `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all registers use it |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Raw asynchronous serial line, idle high |
| baud_div | input | DIV_W | Clock cycles per oversample tick (0 is treated as 1) |
| len_sel | input | 2 | Character length: 0..3 selects 5..8 bits |
| two_stop | input | 1 | 1 = two stop bits, 0 = one |
| rx_data | output | DATA_MAX | Last received character, right-justified |
| rx_valid | output | 1 | One-cycle pulse when a character completes |
| frame_err | output | 1 | Framing error flag for the last character |
| busy | output | 1 | Receiver is inside a character or waiting for line high |

## Verification
A wrong tick count or a bit index that is off by one shows up within a single character. The received byte comes out rotated or shifted, or with stray upper bits, in the same cycle as that character's `rx_valid`. A wrong start-qualification or end-of-frame state shows up as a missing or extra `rx_valid` pulse. It also shows up as `busy` staying high or dropping too early, visible within one bit time of a glitch or a break. Framing-flag errors appear on the next `rx_valid`, and the next good character confirms that the flag clears.

// File: rtl/sfr_pkg.sv
// Shared types and helpers for the serial frame receiver.
// Assumes the character length select is a two-bit code (0..3 -> 5..8 bits).
package sfr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_HOLD
    } rx_state_t;

endpackage

// File: rtl/sfr_sync.sv
// Multi-stage synchroniser for the asynchronous serial input.
// Assumes the line idles high, so every stage resets to 1.
module sfr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] stage_q;

    // shift the raw input through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '1;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], din};
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/sfr_tick_gen.sv
// Oversample enable generator: one-cycle tick every div_in clock cycles.
// A restart pulse zeroes the phase so the first tick lands exactly div_in
// cycles later. A divisor of zero is treated as one.
module sfr_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_in,
    input  logic             restart,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_last;

    assign div_last = (div_in == '0) ? '0 : div_in - 1'b1;
    assign tick     = (cnt_q == div_last) && !restart;

    // free-running phase counter, cleared on restart or wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || cnt_q >= div_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sfr_engine.sv
// Receive state machine: start qualification, centre sampling of data and
// stop bits, result registers. Assumes rx_s is already synchronised and that
// tick is the oversample enable (OVS ticks per bit). len_sel and two_stop
// are assumed steady during a character.
module sfr_engine
    import sfr_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int DATA_MAX = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_s,
    input  logic                tick,
    input  logic [1:0]          len_sel,
    input  logic                two_stop,
    output logic                restart,
    output logic [DATA_MAX-1:0] data_out,
    output logic                valid_out,
    output logic                ferr_out,
    output logic                busy_out
);

    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_MAX);
    localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] MIN_LAST  = IDX_W'(DATA_MAX - 4);

    rx_state_t           state_q;
    logic [CNT_W-1:0]    ovs_q;
    logic [IDX_W-1:0]    idx_q;
    logic                stop2_q;
    logic                err_acc_q;
    logic                prev_q;
    logic [DATA_MAX-1:0] shift_q;
    logic [DATA_MAX-1:0] data_q;
    logic                valid_q;
    logic                ferr_q;
    logic [IDX_W-1:0]    last_idx;
    logic                fall;

    assign last_idx  = MIN_LAST + IDX_W'(len_sel);
    assign fall      = prev_q && !rx_s;
    assign restart   = (state_q == ST_IDLE) && fall;
    assign data_out  = data_q;
    assign valid_out = valid_q;
    assign ferr_out  = ferr_q;
    assign busy_out  = (state_q != ST_IDLE);

    // keep the previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= rx_s;
    end

    // frame sequencing and sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ovs_q     <= '0;
            idx_q     <= '0;
            stop2_q   <= 1'b0;
            err_acc_q <= 1'b0;
            shift_q   <= '0;
            data_q    <= '0;
            valid_q   <= 1'b0;
            ferr_q    <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (fall) begin
                        state_q <= ST_START;
                        ovs_q   <= '0;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (ovs_q == MID_TICK) begin
                            ovs_q <= '0;
                            if (!rx_s) begin
                                state_q   <= ST_DATA;
                                idx_q     <= '0;
                                shift_q   <= '0;
                                err_acc_q <= 1'b0;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            ovs_q <= ovs_q + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        if (ovs_q == LAST_TICK) begin
                            ovs_q          <= '0;
                            shift_q[idx_q] <= rx_s;
                            if (idx_q == last_idx) begin
                                state_q <= ST_STOP;
                                stop2_q <= 1'b0;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end else begin
                            ovs_q <= ovs_q + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (ovs_q == LAST_TICK) begin
                            ovs_q <= '0;
                            if (two_stop && !stop2_q) begin
                                err_acc_q <= err_acc_q | !rx_s;
                                stop2_q   <= 1'b1;
                            end else begin
                                data_q  <= shift_q;
                                ferr_q  <= err_acc_q | !rx_s;
                                valid_q <= 1'b1;
                                state_q <= ST_HOLD;
                            end
                        end else begin
                            ovs_q <= ovs_q + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (rx_s) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/serial_frame_rx.sv
// Top level of the runtime-configurable serial receiver. Joins the input
// synchroniser, the oversample tick generator and the receive engine.
// Assumes the system clock runs at least OVS times the bit rate.
module serial_frame_rx #(
    parameter int DIV_W     = 16,
    parameter int OVS       = 16,
    parameter int DATA_MAX  = 8,
    parameter int SYNC_LEN  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_line,
    input  logic [DIV_W-1:0]    baud_div,
    input  logic [1:0]          len_sel,
    input  logic                two_stop,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_valid,
    output logic                frame_err,
    output logic                busy
);

    logic rx_s;
    logic tick;
    logic restart;

    sfr_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_line),
        .dout  (rx_s)
    );

    sfr_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_in  (baud_div),
        .restart (restart),
        .tick    (tick)
    );

    sfr_engine #(.OVS(OVS), .DATA_MAX(DATA_MAX)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_s      (rx_s),
        .tick      (tick),
        .len_sel   (len_sel),
        .two_stop  (two_stop),
        .restart   (restart),
        .data_out  (rx_data),
        .valid_out (rx_valid),
        .ferr_out  (frame_err),
        .busy_out  (busy)
    );

endmodule

// File: rtl/sfr_checker.sv
// Temporal checks on the serial receiver ports, attached by bind.
// Assumes rx_s is the synchronised line inside the top module.
module sfr_checker #(
    parameter int DATA_MAX = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rx_valid,
    input logic                busy,
    input logic                frame_err,
    input logic [DATA_MAX-1:0] rx_data,
    input logic                rx_s
);

    // R9: the valid pulse lasts one cycle
    a_r9_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9: a character completes only while the receiver is busy
    a_r9_valid_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy);

    // R10: the data register moves only with a valid pulse
    a_r10_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> rx_valid);

    // R10: the framing flag moves only with a valid pulse
    a_r10_err_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_err) |-> rx_valid);

    // R8: the receiver goes idle only after seeing the line high
    a_r8_idle_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(rx_s));

endmodule

bind serial_frame_rx sfr_checker #(.DATA_MAX(DATA_MAX)) u_sfr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .busy      (busy),
    .frame_err (frame_err),
    .rx_data   (rx_data),
    .rx_s      (rx_s)
);

// File: tb/serial_frame_rx_test.sv
module serial_frame_rx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic [15:0] baud_div = 16'd2;
    logic [1:0]  len_sel = 2'd3;
    logic        two_stop = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        frame_err;
    logic        busy;

    int n_checks = 0;
    int n_fails  = 0;
    int valid_cnt = 0;
    int run_len = 0;
    int max_run = 0;
    int cycles = 0;
    logic [7:0] last_data = '0;
    logic       last_err = 1'b0;

    always #2 clk = ~clk;

    serial_frame_rx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_line   (rx_line),
        .baud_div  (baud_div),
        .len_sel   (len_sel),
        .two_stop  (two_stop),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .frame_err (frame_err),
        .busy      (busy)
    );

    // output monitor, sampled away from the active edge
    always @(negedge clk) begin
        cycles = cycles + 1;
        if (rst_n && rx_valid) begin
            valid_cnt = valid_cnt + 1;
            last_data = rx_data;
            last_err  = frame_err;
            run_len   = run_len + 1;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
        if (cycles > 150000) begin
            n_checks = n_checks + 1;
            n_fails  = n_fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int actual, input int expected);
        n_checks = n_checks + 1;
        if (actual != expected) begin
            n_fails = n_fails + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, actual, expected);
        end
    endtask

    task automatic hold_bits(input logic lvl, input int nbits);
        rx_line = lvl;
        repeat (nbits * 16 * ((baud_div == 0) ? 1 : int'(baud_div))) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nbits,
                              input int nstop, input logic s1, input logic s2);
        hold_bits(1'b0, 1);
        for (int i = 0; i < nbits; i++) hold_bits(d[i], 1);
        hold_bits(s1, 1);
        if (nstop == 2) hold_bits(s2, 1);
        hold_bits(1'b1, 2);
    endtask

    task automatic frame_check(input string tag, input logic [7:0] d, input int nbits,
                               input int nstop, input logic s1, input logic s2,
                               input logic [7:0] exp_d, input logic exp_err);
        int v0;
        v0 = valid_cnt;
        send_frame(d, nbits, nstop, s1, s2);
        chk({tag, " valid count"}, valid_cnt - v0, 1);
        chk({tag, " data"}, last_data, exp_d);
        chk({tag, " frame_err"}, last_err, exp_err);
        chk({tag, " busy idle"}, busy, 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", rx_valid, 0);
        chk("R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", rx_valid, 0);
        chk("R1 busy after reset", busy, 0);
        chk("R1 frame_err after reset", frame_err, 0);
        chk("R1 data after reset", rx_data, 0);
        hold_bits(1'b1, 1);
    endtask

    task automatic t_byte8;
        baud_div = 16'd2; len_sel = 2'd3; two_stop = 1'b0;
        frame_check("R2 byte A5", 8'hA5, 8, 1, 1'b1, 1'b1, 8'hA5, 1'b0);
        frame_check("R2 byte 3C", 8'h3C, 8, 1, 1'b1, 1'b1, 8'h3C, 1'b0);
        frame_check("R2 byte 01", 8'h01, 8, 1, 1'b1, 1'b1, 8'h01, 1'b0);
    endtask

    task automatic t_lengths;
        baud_div = 16'd2; two_stop = 1'b0;
        len_sel = 2'd0;
        frame_check("R3 len5", 8'hFF, 5, 1, 1'b1, 1'b1, 8'h1F, 1'b0);
        len_sel = 2'd1;
        frame_check("R3 len6", 8'hFF, 6, 1, 1'b1, 1'b1, 8'h3F, 1'b0);
        len_sel = 2'd2;
        frame_check("R3 len7", 8'h55, 7, 1, 1'b1, 1'b1, 8'h55, 1'b0);
        len_sel = 2'd3;
    endtask

    task automatic t_two_stop;
        baud_div = 16'd2; len_sel = 2'd3; two_stop = 1'b1;
        frame_check("R4 two stops good", 8'h96, 8, 2, 1'b1, 1'b1, 8'h96, 1'b0);
        frame_check("R4 second stop low", 8'h69, 8, 2, 1'b1, 1'b0, 8'h69, 1'b1);
        frame_check("R10 clear after R4 error", 8'h12, 8, 2, 1'b1, 1'b1, 8'h12, 1'b0);
        two_stop = 1'b0;
    endtask

    task automatic t_ferr;
        baud_div = 16'd2; len_sel = 2'd3; two_stop = 1'b0;
        frame_check("R5 low stop", 8'hC3, 8, 1, 1'b0, 1'b1, 8'hC3, 1'b1);
        frame_check("R10 good clears error", 8'h7E, 8, 1, 1'b1, 1'b1, 8'h7E, 1'b0);
    endtask

    task automatic t_glitch;
        int v0;
        baud_div = 16'd2;
        v0 = valid_cnt;
        rx_line = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 busy after start edge", busy, 1);
        repeat (1) @(negedge clk);
        rx_line = 1'b1;
        hold_bits(1'b1, 2);
        chk("R6 glitch no char", valid_cnt - v0, 0);
        chk("R6 glitch back idle", busy, 0);
    endtask

    task automatic t_divisors;
        len_sel = 2'd3; two_stop = 1'b0;
        baud_div = 16'd1;
        frame_check("R7 div1", 8'hB4, 8, 1, 1'b1, 1'b1, 8'hB4, 1'b0);
        baud_div = 16'd5;
        frame_check("R7 div5", 8'h2D, 8, 1, 1'b1, 1'b1, 8'h2D, 1'b0);
        baud_div = 16'd0;
        frame_check("R7 div0", 8'hE1, 8, 1, 1'b1, 1'b1, 8'hE1, 1'b0);
        baud_div = 16'd2;
    endtask

    task automatic t_break;
        int v0;
        baud_div = 16'd2; len_sel = 2'd3; two_stop = 1'b0;
        v0 = valid_cnt;
        hold_bits(1'b0, 30);
        chk("R8 break one char", valid_cnt - v0, 1);
        chk("R8 break data", last_data, 0);
        chk("R8 break frame_err", last_err, 1);
        chk("R8 busy while low", busy, 1);
        hold_bits(1'b1, 1);
        chk("R8 idle after high", busy, 0);
        frame_check("R8 char after break", 8'h5A, 8, 1, 1'b1, 1'b1, 8'h5A, 1'b0);
    endtask

    initial begin
        t_reset;
        t_byte8;
        t_lengths;
        t_two_stop;
        t_ferr;
        t_glitch;
        t_divisors;
        t_break;
        chk("R9 valid pulse width", max_run, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule